// File: doc/BRIEF.md
# Store Queue Forwarding Age-Range Masker

This block takes two pointers into a circular store queue and works out which entries a load must examine for store-to-load forwarding. The first pointer is the dequeue pointer, which marks the oldest store still held. The second is the load's store-queue index, which marks the first store younger than the load. Each pointer carries a wrap flag above its entry index. The span between the two pointers is split into two entry masks. The older mask holds entries in the dequeue pointer's wrap generation. The wrapped mask holds entries that lie past the wrap-around. Because of this split, a consumer can order all candidates from old to young by placing the wrapped mask above the older mask, and no subtraction is needed.

Each mask bit is also gated by that entry's valid bit and by an address match between the load and the store. The address match works at 8-byte granularity. When address checking is switched off, every match is treated as true and the block produces pure range masks. The block also resolves the youngest surviving candidate. In the concatenated order it picks the highest set position and reports that position's entry index and the mask it came from. The whole block is combinational.

Top module: `fwd_range_masker`

## Requirements
- R1: When the two wrap flags are equal, bit j of `older_mask_o` is set exactly for entries with deq_idx <= j < ld_idx, provided the entry is valid and matches.
- R2: When the two wrap flags are equal, `wrapped_mask_o` is all zeros.
- R3: When the wrap flags differ, `older_mask_o` covers the entries from deq_idx to DEPTH-1. `wrapped_mask_o` covers the entries from 0 to ld_idx-1. Both masks are gated by valid and match.
- R4: With equal flags and equal indices, both masks are zero (an empty span) and `fwd_hit_o` is 0. With different flags and equal indices, the queue is full and every valid, matching entry appears in exactly one of the two masks.
- R5: A mask bit is set only if `st_valid_i[j]` is 1. When `addr_chk_en_i` is 1, bits PA_W-1 down to 3 of entry j's address (field `st_paddr_i[j*PA_W +: PA_W]`) must also equal the same bits of `ld_paddr_i`. Address bits 2 to 0 never affect the result.
- R6: When `addr_chk_en_i` is 0, addresses are ignored and each mask equals its range gated only by valid.
- R7: `fwd_hit_o` is 1 when either mask has a set bit. The selected position is the highest set bit of {wrapped_mask_o, older_mask_o}. `fwd_idx_o` gives that position's entry index. `fwd_wrapped_o` is 1 when the position came from the wrapped mask.
- R8: The span size (load pointer minus dequeue pointer, modulo 2*DEPTH, for spans of at most DEPTH) equals the number of bits set across the two range masks before gating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| deq_flag_i | input | 1 | Wrap flag of the dequeue pointer |
| deq_idx_i | input | IDX_W | Entry index of the dequeue pointer |
| ld_flag_i | input | 1 | Wrap flag of the load's store-queue index |
| ld_idx_i | input | IDX_W | Entry index of the load's store-queue index |
| ld_paddr_i | input | PA_W | Load physical address |
| st_paddr_i | input | DEPTH*PA_W | Store physical addresses, entry j at bits j*PA_W +: PA_W |
| st_valid_i | input | DEPTH | Per-entry store valid |
| addr_chk_en_i | input | 1 | 1 = gate by address match, 0 = treat all addresses as matching |
| older_mask_o | output | DEPTH | Candidates in the dequeue pointer's generation |
| wrapped_mask_o | output | DEPTH | Candidates past the wrap-around |
| fwd_hit_o | output | 1 | Some candidate exists |
| fwd_idx_o | output | IDX_W | Entry index of the youngest candidate |
| fwd_wrapped_o | output | 1 | Youngest candidate lies in the wrapped mask |

## Verification
All results are combinational and are due in the same cycle as the input change. No register lies on any path. The bench therefore applies each stimulus just after a rising edge and samples every output at the following falling edge, half a period later. It sweeps every legal pointer pair of an 8-entry queue. It then runs random valid and address patterns, where the expected masks and pick come from a model that walks entry by entry from the dequeue pointer to the load pointer.

// File: rtl/fwd_range_pkg.sv
`timescale 1ns/1ps
package fwd_range_pkg;
  localparam int MAX_DEPTH = 64;

  // bits lo..hi-1 set, all others clear
  function automatic logic [MAX_DEPTH-1:0] span_bits(input int lo, input int hi);
    logic [MAX_DEPTH-1:0] r;
    r = '0;
    for (int k = 0; k < MAX_DEPTH; k++) r[k] = (k >= lo) && (k < hi);
    return r;
  endfunction
endpackage

// File: rtl/fwd_range_gen.sv
`timescale 1ns/1ps
module fwd_range_gen #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             deq_flag,
  input  logic [IDX_W-1:0] deq_idx,
  input  logic             ld_flag,
  input  logic [IDX_W-1:0] ld_idx,
  output logic [DEPTH-1:0] old_range,
  output logic [DEPTH-1:0] wrap_range,
  output logic             same_gen
);
  import fwd_range_pkg::*;

  logic [MAX_DEPTH-1:0] old_full, wrap_full;

  assign same_gen = (deq_flag == ld_flag);

  always_comb begin
    if (same_gen) begin
      old_full  = span_bits(int'(deq_idx), int'(ld_idx));
      wrap_full = '0;
    end else begin
      old_full  = span_bits(int'(deq_idx), DEPTH);
      wrap_full = span_bits(0, int'(ld_idx));
    end
  end

  assign old_range  = old_full[DEPTH-1:0];
  assign wrap_range = wrap_full[DEPTH-1:0];

  logic [IDX_W:0] span_len;
  assign span_len = {ld_flag, ld_idx} - {deq_flag, deq_idx};

  always_comb begin
    if (!$isunknown({deq_flag, deq_idx, ld_flag, ld_idx})) begin
      AST_SAME_GEN_NO_WRAP: assert (!same_gen || wrap_range == '0); // R2
      if (int'(span_len) <= DEPTH)
        AST_SPAN_POPCOUNT: assert ($countones(old_range) + $countones(wrap_range) == int'(span_len)); // R8
    end
  end
endmodule

// File: rtl/fwd_addr_match.sv
`timescale 1ns/1ps
module fwd_addr_match #(
  parameter int DEPTH = 8,
  parameter int PA_W  = 16,
  localparam int TAG_W = PA_W - 3
) (
  input  logic [PA_W-1:0]       ld_paddr,
  input  logic [DEPTH*PA_W-1:0] st_paddr,
  input  logic                  chk_en,
  output logic [DEPTH-1:0]      hit_vec
);
  logic [TAG_W-1:0] ld_tag;
  assign ld_tag = ld_paddr[PA_W-1:3];

  for (genvar j = 0; j < DEPTH; j++) begin : g_cmp
    logic [TAG_W-1:0] st_tag;
    assign st_tag     = st_paddr[j*PA_W+3 +: TAG_W];
    assign hit_vec[j] = !chk_en || (st_tag == ld_tag);
  end
endmodule

// File: rtl/fwd_youngest_pick.sv
`timescale 1ns/1ps
module fwd_youngest_pick #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int POS_W = IDX_W + 1
) (
  input  logic [DEPTH-1:0] cand_old,
  input  logic [DEPTH-1:0] cand_wrap,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx,
  output logic             hit_wrapped
);
  logic [2*DEPTH-1:0] cand;
  logic [POS_W-1:0]   pos;

  function automatic logic [POS_W:0] top_set(input logic [2*DEPTH-1:0] c);
    logic [POS_W:0] r;
    r = '0;
    for (int k = 0; k < 2*DEPTH; k++)
      if (c[k]) r = {1'b1, POS_W'(k)};
    return r;
  endfunction

  assign cand = {cand_wrap, cand_old};
  assign {hit, pos} = top_set(cand);
  assign hit_idx     = pos[IDX_W-1:0];
  assign hit_wrapped = pos[IDX_W];

  always_comb begin
    if (!$isunknown(cand)) begin
      AST_PICK_IS_CAND: assert (!hit || cand[pos]); // R7
      AST_PICK_YOUNGEST: assert (!hit || (cand >> pos) == 1); // R7
      AST_NO_CAND_NO_HIT: assert (hit || cand == '0); // R7
    end
  end
endmodule

// File: rtl/fwd_range_masker.sv
`timescale 1ns/1ps
module fwd_range_masker #(
  parameter int DEPTH = 8,
  parameter int PA_W  = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                  deq_flag_i,
  input  logic [IDX_W-1:0]      deq_idx_i,
  input  logic                  ld_flag_i,
  input  logic [IDX_W-1:0]      ld_idx_i,
  input  logic [PA_W-1:0]       ld_paddr_i,
  input  logic [DEPTH*PA_W-1:0] st_paddr_i,
  input  logic [DEPTH-1:0]      st_valid_i,
  input  logic                  addr_chk_en_i,
  output logic [DEPTH-1:0]      older_mask_o,
  output logic [DEPTH-1:0]      wrapped_mask_o,
  output logic                  fwd_hit_o,
  output logic [IDX_W-1:0]      fwd_idx_o,
  output logic                  fwd_wrapped_o
);
  logic [DEPTH-1:0] old_range, wrap_range, addr_hit;
  logic             same_gen;

  fwd_range_gen #(.DEPTH(DEPTH)) u_range (
    .deq_flag  (deq_flag_i),
    .deq_idx   (deq_idx_i),
    .ld_flag   (ld_flag_i),
    .ld_idx    (ld_idx_i),
    .old_range (old_range),
    .wrap_range(wrap_range),
    .same_gen  (same_gen)
  );

  fwd_addr_match #(.DEPTH(DEPTH), .PA_W(PA_W)) u_match (
    .ld_paddr(ld_paddr_i),
    .st_paddr(st_paddr_i),
    .chk_en  (addr_chk_en_i),
    .hit_vec (addr_hit)
  );

  assign older_mask_o   = old_range  & st_valid_i & addr_hit;
  assign wrapped_mask_o = wrap_range & st_valid_i & addr_hit;

  fwd_youngest_pick #(.DEPTH(DEPTH)) u_pick (
    .cand_old   (older_mask_o),
    .cand_wrap  (wrapped_mask_o),
    .hit        (fwd_hit_o),
    .hit_idx    (fwd_idx_o),
    .hit_wrapped(fwd_wrapped_o)
  );

  always_comb begin
    if (!$isunknown({deq_flag_i, deq_idx_i, ld_flag_i, ld_idx_i, st_valid_i, addr_hit})) begin
      AST_MASK_NEEDS_VALID: assert (((older_mask_o | wrapped_mask_o) & ~st_valid_i) == '0); // R5
      AST_EMPTY_SPAN: assert (!(same_gen && deq_idx_i == ld_idx_i) || !fwd_hit_o); // R4
      AST_FULL_DISJOINT: assert (same_gen || deq_idx_i != ld_idx_i || (old_range & wrap_range) == '0); // R4
    end
  end
endmodule

// File: tb/fwd_range_masker_test.sv
`timescale 1ns/1ps
module fwd_range_masker_test;
  localparam int DEPTH = 8;
  localparam int PA_W  = 16;
  localparam int IDX_W = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                  deq_flag = 1'b0;
  logic [IDX_W-1:0]      deq_idx = '0;
  logic                  ld_flag = 1'b0;
  logic [IDX_W-1:0]      ld_idx = '0;
  logic [PA_W-1:0]       ld_paddr = '0;
  logic [DEPTH*PA_W-1:0] st_paddr = '0;
  logic [DEPTH-1:0]      st_valid = '0;
  logic                  chk_en = 1'b0;
  logic [DEPTH-1:0]      older_mask, wrapped_mask;
  logic                  fwd_hit, fwd_wrapped;
  logic [IDX_W-1:0]      fwd_idx;

  fwd_range_masker #(.DEPTH(DEPTH), .PA_W(PA_W)) uut (
    .deq_flag_i(deq_flag), .deq_idx_i(deq_idx), .ld_flag_i(ld_flag), .ld_idx_i(ld_idx),
    .ld_paddr_i(ld_paddr), .st_paddr_i(st_paddr), .st_valid_i(st_valid),
    .addr_chk_en_i(chk_en), .older_mask_o(older_mask), .wrapped_mask_o(wrapped_mask),
    .fwd_hit_o(fwd_hit), .fwd_idx_o(fwd_idx), .fwd_wrapped_o(fwd_wrapped)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // walk from dequeue pointer to load pointer, one entry at a time
  task automatic model(input int dq, input int lq, output logic [DEPTH-1:0] eo,
                       output logic [DEPTH-1:0] ew, output logic [4:0] epick);
    logic [DEPTH-1:0] m;
    int p;
    eo = '0; ew = '0; epick = '0;
    for (int j = 0; j < DEPTH; j++)
      m[j] = !chk_en || (st_paddr[j*PA_W+3 +: PA_W-3] == ld_paddr[PA_W-1:3]);
    p = dq;
    while (p != lq) begin
      int idx = p % DEPTH;
      bit wr  = (p / DEPTH) != (dq / DEPTH);
      if (st_valid[idx] && m[idx]) begin
        if (wr) ew[idx] = 1'b1; else eo[idx] = 1'b1;
        epick = {1'b1, wr, 3'(idx)};
      end
      p = (p + 1) % (2*DEPTH);
    end
  endtask

  task automatic apply_and_check(input int dq, input int lq, input string rm, input string rh);
    logic [DEPTH-1:0] eo, ew;
    logic [4:0] ep, ap;
    @(posedge clk); #0.5;
    {deq_flag, deq_idx} = 4'(dq);
    {ld_flag, ld_idx}   = 4'(lq);
    @(negedge clk);
    model(dq, lq, eo, ew, ep);
    chk({rm, " older"}, 32'(older_mask), 32'(eo));
    chk({rm, " wrapped"}, 32'(wrapped_mask), 32'(ew));
    ap = fwd_hit ? {1'b1, fwd_wrapped, fwd_idx} : 5'b0;
    chk({rh, " pick"}, 32'(ap), 32'(ep));
  endtask

  function automatic string range_tag(input int dq, input int lq);
    bit same = (dq / DEPTH) == (lq / DEPTH);
    if ((dq % DEPTH) == (lq % DEPTH)) return "R4";
    return same ? "R1/R2" : "R3";
  endfunction

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // idle state: equal pointers, empty span
    @(negedge clk);
    chk("R4 idle older", 32'(older_mask), 0);
    chk("R4 idle wrapped", 32'(wrapped_mask), 0);
    chk("R4 idle hit", 32'(fwd_hit), 0);

    // R1 R2 R3 R4 R8: sweep every legal pointer pair, pure ranges
    st_valid = '1; chk_en = 1'b0;
    for (int dq = 0; dq < 2*DEPTH; dq++)
      for (int lq = 0; lq < 2*DEPTH; lq++)
        if (((lq - dq + 2*DEPTH) % (2*DEPTH)) <= DEPTH)
          apply_and_check(dq, lq, range_tag(dq, lq), "R7");

    // R5: low three address bits ignored; full queue selects every entry once (R4)
    chk_en = 1'b1; ld_paddr = 16'h1234;
    for (int j = 0; j < DEPTH; j++) st_paddr[j*PA_W +: PA_W] = 16'h1234 ^ 16'(j % 8);
    apply_and_check(8 + 3, 3, "R5", "R7");
    chk("R4 full covers all", 32'(older_mask | wrapped_mask), 32'hFF);
    // R5: bit 3 differs -> nothing matches
    for (int j = 0; j < DEPTH; j++) st_paddr[j*PA_W +: PA_W] = 16'h1234 ^ 16'h0008;
    apply_and_check(2, 8 + 2, "R5", "R7");
    chk("R5 bit3 mismatch hit", 32'(fwd_hit), 0);
    // R6: disable address check with mismatching addresses
    chk_en = 1'b0;
    apply_and_check(2, 8 + 2, "R6", "R7");

    // R5 R6 R7: random valid and address patterns
    for (int t = 0; t < 400; t++) begin
      int dq = $urandom_range(0, 2*DEPTH-1);
      int lq = (dq + $urandom_range(0, DEPTH)) % (2*DEPTH);
      st_valid = DEPTH'($urandom);
      chk_en   = ($urandom_range(0, 3) != 0);
      ld_paddr = 16'($urandom);
      for (int j = 0; j < DEPTH; j++)
        st_paddr[j*PA_W +: PA_W] = $urandom_range(0, 1) ? (ld_paddr ^ 16'($urandom_range(0, 7)))
                                                        : (ld_paddr ^ (16'h8 << $urandom_range(0, PA_W-4)));
      apply_and_check(dq, lq, chk_en ? "R5" : "R6", "R7");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule